// File: doc/BRIEF.md
# SPI Master with Independent Transmit and Receive Byte Counts

This block is a register-programmed SPI master. One start request runs one transaction. The transaction clocks out bytes from a transmit buffer and captures bytes into a receive buffer. The transmit and receive byte counts are programmed separately. The number of bytes on the wire is the larger of the two counts. Once the transmit count runs out, the master sends a programmable filler byte. Once the receive count runs out, further incoming bytes are dropped.

Software controls the block through a single-cycle register write port and a combinational read port. Trigger registers request a start or a stop. Five sticky event flags report progress: started, transmit done, receive done, all done and stopped. A byte-read port (index out, data in the same cycle) stands in for a memory read of the transmit buffer. A byte-write port with an index delivers each received byte. The system clock is assumed to be 16 MHz, and the serial clock rate is divided down from it.

Top module: `spi_xfer_master`

## Requirements
- R1: After reset the rate register reads 0x0400_0000, every pin-select register reads 0xFFFF_FFFF, the enable register and all events read 0, sck_o is low and both pin enables are low.
- R2: Writing 7 to the enable register (address 7) turns the master on and writing 0 turns it off. Pin selects sit at addresses 15 (clock), 16 (data out) and 17 (data in). Each keeps bits 4:0 and bit 31. A pin's output enable is high only while the master is on and bit 31 of that pin's select is clear.
- R3: A transaction moves max(tx count, rx count) bytes. Byte i on the data-out line is transmit-buffer entry i while i < tx count, and the filler byte (address 14) otherwise. The tx count is at address 10 and the rx count at address 11.
- R4: Byte i sampled from the data-in line is written to receive index i only when i < rx count. No other receive write occurs.
- R5: Config bits (address 8) select the serial format: bit 0 set means least significant bit first, bit 1 is clock phase, bit 2 is clock polarity. The clock idles at the polarity level. Data is sampled on the leading edge when phase is 0 and on the trailing edge when phase is 1.
- R6: The rate register (address 9) accepts one-hot codes from bit 25 (125 kHz, half period 64 cycles) to bit 31 (8 MHz, half period 1 cycle). Each higher bit halves the half period. Any other code gives a half period of 32 cycles.
- R7: Events occupy addresses 2 (started), 3 (all done), 4 (transmit done), 5 (receive done) and 6 (stopped), readable in bit 0. Transmit done is raised after the last counted transmit byte. Receive done is raised after the last counted receive byte. All done is raised after the final byte. Each flag stays set until software writes 0 to it.
- R8: A start request (write 1 to address 0) is ignored while the master is off or a transaction is running.
- R9: A stop request (write 1 to address 1) ends any transaction on the next cycle. It raises the stopped event, does not raise all done, and returns the clock to idle.
- R10: The amount registers (address 12 transmit, 13 receive) report the counted bytes actually moved in the latest transaction.
- R11: A start with both counts 0 raises started, all done, transmit done and receive done at once, without any clock edge.
- R12: While bit 31 of the data-in pin select is set, the sampled data-in line reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| tx_rd_idx_o | output | 8 | Transmit buffer index being fetched |
| tx_rd_data_i | input | 8 | Transmit buffer byte at tx_rd_idx_o |
| rx_wr_en_o | output | 1 | Receive buffer write strobe |
| rx_wr_idx_o | output | 8 | Receive buffer index |
| rx_wr_data_o | output | 8 | Received byte |
| sck_o | output | 1 | Serial clock |
| sck_oe_o | output | 1 | Serial clock pin enable |
| mosi_o | output | 1 | Serial data out |
| mosi_oe_o | output | 1 | Data-out pin enable |
| miso_i | input | 1 | Serial data in |

## Verification
Three kinds of internal fault have distinct signatures at the ports. A wrong byte index or a wrong stored count shows up within one byte time: data-out carries the wrong buffer byte or the filler too early, or a receive write lands on the wrong index. A wrong half-period decode or phase setting moves the sample edges that the bench's serial slave records, so the edge spacing or the captured bits differ on the first bit. A stuck busy or event state appears as a missing or early flag when software polls the event registers, or as a clock that never returns to its idle level.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  localparam int ADDR_W = 5;

  typedef enum logic [ADDR_W-1:0] {
    A_START      = 5'd0,
    A_STOP       = 5'd1,
    A_EV_STARTED = 5'd2,
    A_EV_END     = 5'd3,
    A_EV_ENDTX   = 5'd4,
    A_EV_ENDRX   = 5'd5,
    A_EV_STOPPED = 5'd6,
    A_ENABLE     = 5'd7,
    A_CONFIG     = 5'd8,
    A_RATE       = 5'd9,
    A_TX_MAX     = 5'd10,
    A_RX_MAX     = 5'd11,
    A_TX_AMT     = 5'd12,
    A_RX_AMT     = 5'd13,
    A_FILL       = 5'd14,
    A_PIN_SCK    = 5'd15,
    A_PIN_MOSI   = 5'd16,
    A_PIN_MISO   = 5'd17
  } reg_addr_e;

  // event bit positions, offset from A_EV_STARTED
  localparam int EV_STARTED = 0;
  localparam int EV_END     = 1;
  localparam int EV_ENDTX   = 2;
  localparam int EV_ENDRX   = 3;
  localparam int EV_STOPPED = 4;
  localparam int NUM_EV     = 5;

  localparam int PIN_SCK  = 0;
  localparam int PIN_MOSI = 1;
  localparam int PIN_MISO = 2;
  localparam int NUM_PINS = 3;
  localparam logic [31:0] PIN_MASK = 32'h8000_001F;
  localparam logic [31:0] RATE_RST = 32'h0400_0000;

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic lsb_first;
  } spi_cfg_t;
endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
  parameter int SYS_CLK_HZ = 16_000_000,
  parameter int MIN_HZ     = 125_000,
  parameter int STEPS      = 7,
  parameter int CODE_LSB   = 25
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] code_i,
  input  logic        run_i,
  output logic        tick_o
);
  localparam int BASE_HALF = SYS_CLK_HZ / (2 * MIN_HZ);
  localparam int CNT_W     = $clog2(BASE_HALF + 1);

  logic [STEPS-1:0] hit;
  logic [CNT_W-1:0] half_len, cnt_q;

  for (genvar k = 0; k < STEPS; k++) begin : g_step
    assign hit[k] = (code_i == (32'd1 << (CODE_LSB + k)));
  end

  always_comb begin
    half_len = CNT_W'(BASE_HALF >> 1);  // fallback: second step
    for (int k = 0; k < STEPS; k++) begin
      if (hit[k]) half_len = CNT_W'(BASE_HALF >> k);
    end
  end

  assign tick_o = run_i && (cnt_q == half_len - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  input  logic         tick_i,
  input  logic         lsb_first_i,
  input  logic         miso_i,
  output logic         mosi_o,
  output logic         half_o,
  output logic         done_o,
  output logic [W-1:0] rx_o
);
  localparam int BW = $clog2(W);

  logic [W-1:0]  tx_q, rx_q;
  logic [BW-1:0] bit_q;
  logic          half_q;

  // half 0: before sample point, half 1: after it
  assign done_o = tick_i && half_q && (bit_q == BW'(W - 1));
  assign mosi_o = lsb_first_i ? tx_q[0] : tx_q[W-1];
  assign half_o = half_q;
  assign rx_o   = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= '0;
      rx_q   <= '0;
      bit_q  <= '0;
      half_q <= 1'b0;
    end else if (load_i) begin
      tx_q   <= load_data_i;
      bit_q  <= '0;
      half_q <= 1'b0;
    end else if (tick_i) begin
      if (!half_q) begin
        half_q <= 1'b1;
        rx_q   <= lsb_first_i ? {miso_i, rx_q[W-1:1]} : {rx_q[W-2:0], miso_i};
      end else begin
        half_q <= 1'b0;
        bit_q  <= bit_q + 1'b1;
        tx_q   <= lsb_first_i ? (tx_q >> 1) : (tx_q << 1);
      end
    end
  end
endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master
  import spi_xfer_pkg::*;
#(
  parameter int SYS_CLK_HZ = 16_000_000,
  parameter int CNT_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [4:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic [CNT_W-1:0]  tx_rd_idx_o,
  input  logic [7:0]        tx_rd_data_i,
  output logic              rx_wr_en_o,
  output logic [CNT_W-1:0]  rx_wr_idx_o,
  output logic [7:0]        rx_wr_data_o,
  output logic              sck_o,
  output logic              sck_oe_o,
  output logic              mosi_o,
  output logic              mosi_oe_o,
  input  logic              miso_i
);
  logic              en_q;
  spi_cfg_t          cfg_q;
  logic [31:0]       rate_q;
  logic [CNT_W-1:0]  txmax_q, rxmax_q, txn_q, rxn_q, len_q, idx_q, tx_amt_q, rx_amt_q;
  logic [7:0]        fill_q;
  logic [31:0]       pin_q [NUM_PINS];
  logic [NUM_EV-1:0] ev_q, ev_set, ev_clr;
  logic              busy_q, need_load_q;

  logic tick, done, eng_mosi, eng_half, miso_eff;
  logic [7:0] eng_rx, load_byte;

  wire start_acc = reg_we_i && reg_addr_i == A_START && reg_wdata_i[0] && en_q && !busy_q;
  wire stop_req  = reg_we_i && reg_addr_i == A_STOP && reg_wdata_i[0];
  wire zero_len  = start_acc && txmax_q == '0 && rxmax_q == '0;
  wire done_ok   = done && busy_q && en_q && !stop_req;
  wire last_byte = idx_q == len_q - 1'b1;
  wire tx_last   = txn_q != '0 && idx_q == txn_q - 1'b1;
  wire rx_last   = rxn_q != '0 && idx_q == rxn_q - 1'b1;

  // ---------------- configuration registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      cfg_q   <= '0;
      rate_q  <= RATE_RST;
      txmax_q <= '0;
      rxmax_q <= '0;
      fill_q  <= '0;
      for (int p = 0; p < NUM_PINS; p++) pin_q[p] <= '1;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        A_ENABLE: begin
          if (reg_wdata_i == 32'd7)      en_q <= 1'b1;
          else if (reg_wdata_i == '0)    en_q <= 1'b0;
        end
        A_CONFIG: cfg_q   <= spi_cfg_t'(reg_wdata_i[2:0]);
        A_RATE:   rate_q  <= reg_wdata_i;
        A_TX_MAX: txmax_q <= reg_wdata_i[CNT_W-1:0];
        A_RX_MAX: rxmax_q <= reg_wdata_i[CNT_W-1:0];
        A_FILL:   fill_q  <= reg_wdata_i[7:0];
        default: ;
      endcase
      for (int p = 0; p < NUM_PINS; p++)
        if (reg_addr_i == 5'(int'(A_PIN_SCK) + p)) pin_q[p] <= reg_wdata_i & PIN_MASK;
    end
  end

  // ---------------- sticky events, hardware set wins
  always_comb begin
    for (int k = 0; k < NUM_EV; k++)
      ev_clr[k] = reg_we_i && reg_addr_i == 5'(int'(A_EV_STARTED) + k) && reg_wdata_i == '0;
    ev_set              = '0;
    ev_set[EV_STARTED]  = start_acc;
    ev_set[EV_END]      = zero_len || (done_ok && last_byte);
    ev_set[EV_ENDTX]    = zero_len || (done_ok && (tx_last || (last_byte && txn_q == '0)));
    ev_set[EV_ENDRX]    = zero_len || (done_ok && (rx_last || (last_byte && rxn_q == '0)));
    ev_set[EV_STOPPED]  = stop_req;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ev_q <= '0;
    else         ev_q <= (ev_q & ~ev_clr) | ev_set;
  end

  // ---------------- transaction sequencer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      need_load_q <= 1'b0;
      idx_q       <= '0;
      len_q       <= '0;
      txn_q       <= '0;
      rxn_q       <= '0;
      tx_amt_q    <= '0;
      rx_amt_q    <= '0;
    end else if (stop_req || !en_q) begin
      busy_q      <= 1'b0;
      need_load_q <= 1'b0;
    end else if (start_acc) begin
      busy_q      <= !zero_len;
      need_load_q <= !zero_len;
      idx_q       <= '0;
      len_q       <= (txmax_q > rxmax_q) ? txmax_q : rxmax_q;
      txn_q       <= txmax_q;
      rxn_q       <= rxmax_q;
      tx_amt_q    <= '0;
      rx_amt_q    <= '0;
    end else if (done_ok) begin
      if (idx_q < txn_q) tx_amt_q <= tx_amt_q + 1'b1;
      if (idx_q < rxn_q) rx_amt_q <= rx_amt_q + 1'b1;
      if (last_byte) begin
        busy_q <= 1'b0;
      end else begin
        idx_q       <= idx_q + 1'b1;
        need_load_q <= 1'b1;
      end
    end else if (need_load_q) begin
      need_load_q <= 1'b0;
    end
  end

  assign tx_rd_idx_o = idx_q;
  assign load_byte   = (idx_q < txn_q) ? tx_rd_data_i : fill_q;
  assign miso_eff    = pin_q[PIN_MISO][31] ? 1'b0 : miso_i;

  spi_rate_gen #(.SYS_CLK_HZ(SYS_CLK_HZ)) u_rate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .code_i (rate_q),
    .run_i  (busy_q && !need_load_q),
    .tick_o (tick)
  );

  spi_byte_engine #(.W(8)) u_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (need_load_q),
    .load_data_i (load_byte),
    .tick_i      (tick),
    .lsb_first_i (cfg_q.lsb_first),
    .miso_i      (miso_eff),
    .mosi_o      (eng_mosi),
    .half_o      (eng_half),
    .done_o      (done),
    .rx_o        (eng_rx)
  );

  assign sck_o     = cfg_q.cpol ^ (busy_q && (cfg_q.cpha ^ (eng_half && !need_load_q)));
  assign mosi_o    = busy_q && eng_mosi;
  assign sck_oe_o  = en_q && !pin_q[PIN_SCK][31];
  assign mosi_oe_o = en_q && !pin_q[PIN_MOSI][31];

  assign rx_wr_en_o   = done_ok && (idx_q < rxn_q);
  assign rx_wr_idx_o  = idx_q;
  assign rx_wr_data_o = eng_rx;

  // ---------------- register read
  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_ENABLE: reg_rdata_o = en_q ? 32'd7 : 32'd0;
      A_CONFIG: reg_rdata_o = {29'd0, cfg_q};
      A_RATE:   reg_rdata_o = rate_q;
      A_TX_MAX: reg_rdata_o = 32'(txmax_q);
      A_RX_MAX: reg_rdata_o = 32'(rxmax_q);
      A_TX_AMT: reg_rdata_o = 32'(tx_amt_q);
      A_RX_AMT: reg_rdata_o = 32'(rx_amt_q);
      A_FILL:   reg_rdata_o = {24'd0, fill_q};
      default: ;
    endcase
    for (int k = 0; k < NUM_EV; k++)
      if (reg_addr_i == 5'(int'(A_EV_STARTED) + k)) reg_rdata_o = {31'd0, ev_q[k]};
    for (int p = 0; p < NUM_PINS; p++)
      if (reg_addr_i == 5'(int'(A_PIN_SCK) + p)) reg_rdata_o = pin_q[p];
  end
endmodule

// File: rtl/spi_xfer_master_chk.sv
module spi_xfer_master_chk
  import spi_xfer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_i,
  input logic              cpol_i,
  input logic              en_i,
  input logic              stop_i,
  input logic              sck_i,
  input logic              sck_oe_i,
  input logic              mosi_oe_i,
  input logic              rx_wr_en_i,
  input logic [CNT_W-1:0]  rx_wr_idx_i,
  input logic [CNT_W-1:0]  txn_i,
  input logic [CNT_W-1:0]  rxn_i,
  input logic [CNT_W-1:0]  tx_amt_i,
  input logic [CNT_W-1:0]  rx_amt_i,
  input logic [NUM_EV-1:0] ev_i
);
  AST_SCK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> sck_i == cpol_i);  // R5
  AST_RX_IDX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_wr_en_i |-> rx_wr_idx_i < rxn_i);  // R4
  AST_PIN_OE_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_oe_i || mosi_oe_i) |-> en_i);  // R2
  AST_STOP_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !busy_i && ev_i[EV_STOPPED]);  // R9
  AST_END_AMOUNTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ev_i[EV_END]) |-> tx_amt_i == txn_i && rx_amt_i == rxn_i);  // R10
  AST_DISABLED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !busy_i);  // R8
endmodule

bind spi_xfer_master spi_xfer_master_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_i      (busy_q),
  .cpol_i      (cfg_q.cpol),
  .en_i        (en_q),
  .stop_i      (stop_req),
  .sck_i       (sck_o),
  .sck_oe_i    (sck_oe_o),
  .mosi_oe_i   (mosi_oe_o),
  .rx_wr_en_i  (rx_wr_en_o),
  .rx_wr_idx_i (rx_wr_idx_o),
  .txn_i       (txn_q),
  .rxn_i       (rxn_q),
  .tx_amt_i    (tx_amt_q),
  .rx_amt_i    (rx_amt_q),
  .ev_i        (ev_q)
);

// File: tb/tb_spi_xfer_master.sv
module tb_spi_xfer_master;
  import spi_xfer_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [7:0]  tx_rd_idx, tx_rd_data, rx_wr_idx, rx_wr_data;
  logic        rx_wr_en, sck, sck_oe, mosi, mosi_oe;
  logic        miso_r = 1'b0;

  logic [7:0] tx_mem [256];
  logic [7:0] miso_bytes [256];
  assign tx_rd_data = tx_mem[tx_rd_idx];

  spi_xfer_master dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .tx_rd_idx_o(tx_rd_idx), .tx_rd_data_i(tx_rd_data),
    .rx_wr_en_o(rx_wr_en), .rx_wr_idx_o(rx_wr_idx), .rx_wr_data_o(rx_wr_data),
    .sck_o(sck), .sck_oe_o(sck_oe), .mosi_o(mosi), .mosi_oe_o(mosi_oe), .miso_i(miso_r)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 1'b0;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- serial slave reference model
  bit cpol_m = 0, cpha_m = 0, lsb_m = 0, miso_off = 0;
  logic sck_prev = 1'b0;
  int edges = 0, rx_seen = 0;
  int edge_t[$];
  logic [7:0] mosi_got[$];
  logic [7:0] cur_mosi = '0;

  function automatic logic miso_bit(input int e);
    int b = e / 8, k = e % 8;
    if (b > 255) return 1'b0;
    return lsb_m ? miso_bytes[b][k] : miso_bytes[b][7-k];
  endfunction

  always @(negedge clk) begin
    if (rst_n && sck !== sck_prev && sck == ~(cpol_m ^ cpha_m)) begin
      int k = edges % 8;
      if (lsb_m) cur_mosi[k] = mosi;
      else       cur_mosi[7-k] = mosi;
      if (k == 7) mosi_got.push_back(cur_mosi);
      edge_t.push_back(cyc);
      edges++;
      miso_r = miso_bit(edges);
    end
    sck_prev = sck;
  end

  // receive port compared every clock against the slave's stream
  always @(negedge clk) begin
    if (rst_n && rx_wr_en) begin
      logic [7:0] exp;
      exp = miso_off ? 8'h00 : miso_bytes[rx_seen];
      chk(rx_wr_idx == 8'(rx_seen), "R4", "rx index", rx_wr_idx, rx_seen);
      chk(rx_wr_data == exp, miso_off ? "R12" : "R4", "rx data", rx_wr_data, exp);
      rx_seen++;
    end
  end

  // ---------------- register access
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic prep(input bit [2:0] cfg, input logic [31:0] rate, input int txn, input int rxn);
    cpol_m = cfg[2]; cpha_m = cfg[1]; lsb_m = cfg[0];
    wr(A_CONFIG, 32'(cfg)); wr(A_RATE, rate);
    wr(A_TX_MAX, 32'(txn)); wr(A_RX_MAX, 32'(rxn));
    for (int i = 0; i < 256; i++) begin
      tx_mem[i]     = 8'(8'h3C + i * 37 + txn);
      miso_bytes[i] = 8'(8'hA5 ^ (i * 11 + rxn));
    end
    for (int k = 0; k < NUM_EV; k++) wr(5'(int'(A_EV_STARTED) + k), 32'd0);
    edges = 0; rx_seen = 0; edge_t.delete(); mosi_got.delete();
    miso_r = miso_bit(0);
  endtask

  task automatic wait_ev(input logic [4:0] a, output bit seen);
    logic [31:0] d;
    seen = 0;
    for (int n = 0; n < 20000 && !seen; n++) begin
      rd(a, d);
      seen = d[0];
    end
  endtask

  task automatic run_xfer(input bit [2:0] cfg, input logic [31:0] rate, input int txn,
                          input int rxn, input int half, input bit restart_mid);
    logic [31:0] d;
    bit seen;
    int len;
    len = (txn > rxn) ? txn : rxn;
    prep(cfg, rate, txn, rxn);
    wr(A_START, 32'd1);
    if (restart_mid) begin
      repeat (30) @(negedge clk);
      wr(A_START, 32'd1);  // R8: ignored while busy
    end
    wait_ev(A_EV_END, seen);
    chk(seen, "R7", "all-done event", seen, 1);
    rd(A_EV_STARTED, d); chk(d[0], "R7", "started event", d, 1);
    rd(A_EV_ENDTX, d);   chk(d[0], len == 0 ? "R11" : "R7", "tx-done event", d, 1);
    rd(A_EV_ENDRX, d);   chk(d[0], len == 0 ? "R11" : "R7", "rx-done event", d, 1);
    chk(edges == len * 8, restart_mid ? "R8" : "R3", "sample edges", edges, len * 8);
    for (int i = 0; i < len && i < mosi_got.size(); i++) begin
      logic [7:0] e;
      e = (i < txn) ? tx_mem[i] : 8'h5A;
      chk(mosi_got[i] == e, "R3", "mosi byte", mosi_got[i], e);
    end
    chk(rx_seen == rxn, "R4", "rx writes", rx_seen, rxn);
    rd(A_TX_AMT, d); chk(d == 32'(txn), "R10", "tx amount", d, txn);
    rd(A_RX_AMT, d); chk(d == 32'(rxn), "R10", "rx amount", d, rxn);
    if (edge_t.size() >= 2)
      chk(edge_t[1] - edge_t[0] == 2 * half, "R6", "sample spacing", edge_t[1] - edge_t[0], 2 * half);
    chk(sck == cfg[2], "R5", "sck idle level", sck, cfg[2]);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", cyc, 150000);
      summary();
    end
  end

  initial begin
    logic [31:0] d;
    bit seen;
    int e0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_RATE, d);       chk(d == 32'h0400_0000, "R1", "rate reset", d, 32'h0400_0000);
    rd(A_PIN_SCK, d);    chk(d == 32'hFFFF_FFFF, "R1", "pin reset", d, 32'hFFFF_FFFF);
    rd(A_EV_STARTED, d); chk(d == 0, "R1", "event reset", d, 0);
    chk(sck == 1'b0 && sck_oe == 1'b0 && mosi_oe == 1'b0, "R1", "pins idle", {sck, sck_oe, mosi_oe}, 0);

    // R8 start while disabled
    wr(A_START, 32'd1);
    rd(A_EV_STARTED, d); chk(d == 0, "R8", "start while off", d, 0);

    // R2 pin selects and enable
    wr(A_PIN_SCK, 32'd3); wr(A_PIN_MOSI, 32'hFFFF_FFE4); wr(A_PIN_MISO, 32'd5);
    rd(A_PIN_SCK, d);  chk(d == 32'd3, "R2", "pin readback", d, 3);
    rd(A_PIN_MOSI, d); chk(d == 32'h8000_0004, "R2", "pin mask", d, 32'h8000_0004);
    chk(sck_oe == 1'b0, "R2", "oe while off", sck_oe, 0);
    wr(A_ENABLE, 32'd7);
    chk(sck_oe == 1'b1 && mosi_oe == 1'b0, "R2", "oe when on", {sck_oe, mosi_oe}, 2'b10);
    wr(A_PIN_MOSI, 32'd4);
    wr(A_FILL, 32'h5A);

    run_xfer(3'b000, 32'h8000_0000, 4, 4, 1, 0);   // R5 mode 0, msb first
    run_xfer(3'b111, 32'h4000_0000, 2, 5, 2, 0);   // R3 filler, R5 mode 3 lsb first
    run_xfer(3'b010, 32'h2000_0000, 6, 1, 4, 0);   // R4 rx shorter, R5 mode 1
    run_xfer(3'b100, 32'h0300_0000, 1, 1, 32, 0);  // R6 invalid code fallback
    run_xfer(3'b000, 32'h8000_0000, 0, 0, 1, 0);   // R11 zero counts
    run_xfer(3'b000, 32'h1000_0000, 3, 3, 8, 1);   // R8 restart while busy

    // R7 tx-done precedes all-done
    prep(3'b000, 32'h8000_0000, 1, 3);
    wr(A_START, 32'd1);
    wait_ev(A_EV_ENDTX, seen);
    chk(seen, "R7", "tx-done seen", seen, 1);
    rd(A_EV_END, d);   chk(d == 0, "R7", "all-done not yet", d, 0);
    rd(A_EV_ENDRX, d); chk(d == 0, "R7", "rx-done not yet", d, 0);
    wait_ev(A_EV_END, seen);
    chk(seen, "R7", "all-done after both", seen, 1);

    // R9 stop mid-transfer at the slowest rate
    prep(3'b000, 32'h0200_0000, 2, 2);
    wr(A_START, 32'd1);
    repeat (300) @(negedge clk);
    wr(A_STOP, 32'd1);
    rd(A_EV_STOPPED, d); chk(d[0], "R9", "stopped event", d, 1);
    rd(A_EV_END, d);     chk(d == 0, "R9", "no all-done", d, 0);
    rd(A_TX_AMT, d);     chk(d == 0, "R10", "tx amount after stop", d, 0);
    chk(sck == 1'b0, "R9", "sck idle after stop", sck, 0);
    if (edge_t.size() >= 2)
      chk(edge_t[1] - edge_t[0] == 128, "R6", "125k spacing", edge_t[1] - edge_t[0], 128);
    e0 = edges;
    repeat (200) @(negedge clk);
    chk(edges == e0, "R9", "no edges after stop", edges, e0);
    rd(A_EV_STOPPED, d); chk(d[0], "R7", "event sticky", d, 1);
    wr(A_EV_STOPPED, 32'd0);
    rd(A_EV_STOPPED, d); chk(d == 0, "R7", "event cleared", d, 0);

    // R12 data-in disconnected
    wr(A_PIN_MISO, 32'h8000_0000);
    miso_off = 1'b1;
    run_xfer(3'b000, 32'h8000_0000, 1, 2, 1, 0);
    miso_off = 1'b0;

    // R2 disable
    wr(A_ENABLE, 32'd0);
    chk(sck_oe == 1'b0, "R2", "oe after disable", sck_oe, 0);
    rd(A_ENABLE, d); chk(d == 0, "R2", "enable readback", d, 0);

    finished = 1'b1;
    summary();
  end
endmodule